// File: doc/BRIEF.md
# Line Compander FIFO

This block holds one video line in a small word-organised buffer and plays it back at a rate set independently of the rate it was filled at. Reading faster than writing squeezes the line in time; reading slower stretches it. That lets a picture shot for one aspect ratio be shown on a screen of another without geometric distortion. Both rates are given as clock enables (`wr_en_i`, `rd_en_i`) inside a single clock domain.

The storage array never sees individual samples. On the write side four consecutive 7-bit samples are gathered and stored as one 28-bit word. On the read side each word is fetched once and handed out as four samples. The array therefore needs at most one access per four samples on each side. A write pointer and a read pointer address the 188 words independently and wrap at the end. A word count gives the full and empty flags. Sticky flags record a word that was dropped while full, and a read that arrived while empty.

Top module: `line_compander`

## Requirements
- R1: While `rst_ni` is low and after it is released, before any strobe, `rd_data_o` is 0, `empty_o` is 1, and `full_o`, `overflow_o` and `underflow_o` are 0.
- R2: Samples come out of `rd_data_o` in the order they were written. A word is formed on the fourth write strobe after a write line start, holding the first sample in bits 6:0 and the fourth in bits 27:21. The first sample of a word appears on the read strobe that fetches it, and samples two to four appear on the next three read strobes.
- R3: The word count rises by one per stored word and falls by one per fetched word, including when both happen in the same cycle. `empty_o` is 1 exactly when the count is 0. `full_o` is 1 exactly when the count is 188.
- R4: A word completed while `full_o` is 1 is not stored. The buffer contents are unchanged, and `overflow_o` goes to 1 and stays there until reset.
- R5: A read strobe that falls on the first sample of a word while `empty_o` is 1 leaves `rd_data_o` unchanged and fetches no word. `underflow_o` goes to 1 and stays there until reset.
- R6: `rd_data_o` changes only on a clock edge where `rd_en_i` is 1, and it shows the new sample right after that edge.
- R7: `wr_line_start_i` takes priority over `wr_en_i`. It clears the write pointer, the pack phase and the word count, so a partly gathered word is discarded and `empty_o` becomes 1.
- R8: `rd_line_start_i` takes priority over `rd_en_i`. It clears the read pointer and the unpack phase, so the next read strobe fetches the word at address 0.
- R9: Both pointers wrap from address 187 to address 0, so a stream longer than 188 words passes through in order.
- R10: Write and read strobes may run at unrelated rates and patterns, and data order and flags stay correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_line_start_i | input | 1 | Restart the write side at the start of a line |
| wr_en_i | input | 1 | Write sample strobe |
| wr_data_i | input | 7 | Write sample |
| rd_line_start_i | input | 1 | Restart the read side at the start of a line |
| rd_en_i | input | 1 | Read sample strobe |
| rd_data_o | output | 7 | Read sample, registered |
| full_o | output | 1 | 188 words stored |
| empty_o | output | 1 | No complete word stored |
| overflow_o | output | 1 | Sticky: a word was dropped while full |
| underflow_o | output | 1 | Sticky: a read arrived while empty |

## Verification
A wrong pack or unpack phase shows up as samples in the wrong order or lanes, within four read strobes of the word concerned. A wrong pointer or wrap shows up as stale or repeated words, but only after the stream has passed 188 words, so long random runs are needed to catch it. A wrong word count appears first in `full_o` or `empty_o`, often on the very cycle where a write and a read land together. It then shows up as a false overflow or underflow, or as old data being repeated, after the next fill or drain.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int unsigned LC_SAMPLE_W = 7;
  localparam int unsigned LC_PACK     = 4;
  localparam int unsigned LC_DEPTH    = 188;
endpackage

// File: rtl/lc_ptr.sv
module lc_ptr #(
  parameter int unsigned DEPTH = lc_pkg::LC_DEPTH,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [AW-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= '0;
    else if (clr_i) ptr_o <= '0;
    else if (inc_i) ptr_o <= (ptr_o == AW'(DEPTH-1)) ? '0 : ptr_o + 1'b1;
  end
endmodule

// File: rtl/lc_pack.sv
module lc_pack #(
  parameter int unsigned SAMPLE_W = lc_pkg::LC_SAMPLE_W,
  parameter int unsigned PACK     = lc_pkg::LC_PACK,
  localparam int unsigned PH_W    = $clog2(PACK),
  localparam int unsigned WORD_W  = SAMPLE_W*PACK
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                en_i,
  input  logic [SAMPLE_W-1:0] data_i,
  output logic [WORD_W-1:0]   word_o,
  output logic                word_vld_o
);
  logic [PH_W-1:0] phase_q;
  logic            last;

  assign last       = (phase_q == PH_W'(PACK-1));
  assign word_vld_o = en_i & ~start_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                phase_q <= '0;
    else if (start_i)           phase_q <= '0;
    else if (en_i)              phase_q <= last ? '0 : phase_q + 1'b1;
  end

  // earlier lanes held, last lane taken straight from the input
  for (genvar g = 0; g < PACK-1; g++) begin : g_lane
    logic [SAMPLE_W-1:0] hold_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hold_q <= '0;
      else if (en_i && !start_i && phase_q == PH_W'(g)) hold_q <= data_i;
    end
    assign word_o[g*SAMPLE_W +: SAMPLE_W] = hold_q;
  end
  assign word_o[(PACK-1)*SAMPLE_W +: SAMPLE_W] = data_i;
endmodule

// File: rtl/lc_unpack.sv
module lc_unpack #(
  parameter int unsigned SAMPLE_W = lc_pkg::LC_SAMPLE_W,
  parameter int unsigned PACK     = lc_pkg::LC_PACK,
  localparam int unsigned PH_W    = $clog2(PACK),
  localparam int unsigned WORD_W  = SAMPLE_W*PACK
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                en_i,
  input  logic                avail_i,
  input  logic [WORD_W-1:0]   word_i,
  output logic                take_o,
  output logic                under_o,
  output logic [SAMPLE_W-1:0] data_o
);
  logic [PH_W-1:0]     phase_q;
  logic [WORD_W-1:0]   word_q;
  logic [SAMPLE_W-1:0] lane [PACK];
  logic                first, last;

  for (genvar g = 0; g < PACK; g++) begin : g_lane
    assign lane[g] = word_q[g*SAMPLE_W +: SAMPLE_W];
  end

  assign first   = (phase_q == '0);
  assign last    = (phase_q == PH_W'(PACK-1));
  assign take_o  = en_i & ~start_i & first & avail_i;
  assign under_o = en_i & ~start_i & first & ~avail_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      word_q  <= '0;
      data_o  <= '0;
    end else if (start_i) begin
      phase_q <= '0;
    end else if (take_o) begin
      word_q  <= word_i;
      data_o  <= word_i[SAMPLE_W-1:0];
      phase_q <= PH_W'(1);
    end else if (en_i && !first) begin
      data_o  <= lane[phase_q];
      phase_q <= last ? '0 : phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/line_compander.sv
module line_compander #(
  parameter int unsigned SAMPLE_W = lc_pkg::LC_SAMPLE_W,
  parameter int unsigned PACK     = lc_pkg::LC_PACK,
  parameter int unsigned DEPTH    = lc_pkg::LC_DEPTH,
  localparam int unsigned WORD_W  = SAMPLE_W*PACK,
  localparam int unsigned AW      = $clog2(DEPTH),
  localparam int unsigned CW      = $clog2(DEPTH+1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_line_start_i,
  input  logic                wr_en_i,
  input  logic [SAMPLE_W-1:0] wr_data_i,
  input  logic                rd_line_start_i,
  input  logic                rd_en_i,
  output logic [SAMPLE_W-1:0] rd_data_o,
  output logic                full_o,
  output logic                empty_o,
  output logic                overflow_o,
  output logic                underflow_o
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] wr_word;
  logic              word_vld, wr_do, rd_take, rd_under;
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     word_cnt;

  lc_pack #(.SAMPLE_W(SAMPLE_W), .PACK(PACK)) i_pack (
    .clk_i, .rst_ni,
    .start_i    (wr_line_start_i),
    .en_i       (wr_en_i),
    .data_i     (wr_data_i),
    .word_o     (wr_word),
    .word_vld_o (word_vld)
  );

  lc_unpack #(.SAMPLE_W(SAMPLE_W), .PACK(PACK)) i_unpack (
    .clk_i, .rst_ni,
    .start_i (rd_line_start_i),
    .en_i    (rd_en_i),
    .avail_i (~empty_o),
    .word_i  (mem[rd_ptr]),
    .take_o  (rd_take),
    .under_o (rd_under),
    .data_o  (rd_data_o)
  );

  lc_ptr #(.DEPTH(DEPTH)) i_wr_ptr (
    .clk_i, .rst_ni, .clr_i(wr_line_start_i), .inc_i(wr_do), .ptr_o(wr_ptr)
  );

  lc_ptr #(.DEPTH(DEPTH)) i_rd_ptr (
    .clk_i, .rst_ni, .clr_i(rd_line_start_i), .inc_i(rd_take), .ptr_o(rd_ptr)
  );

  assign wr_do   = word_vld & ~full_o;
  assign empty_o = (word_cnt == '0);
  assign full_o  = (word_cnt == CW'(DEPTH));

  always_ff @(posedge clk_i) begin
    if (wr_do) mem[wr_ptr] <= wr_word;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              word_cnt <= '0;
    else if (wr_line_start_i) word_cnt <= '0;
    else                      word_cnt <= word_cnt + CW'(wr_do) - CW'(rd_take);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      overflow_o  <= 1'b0;
      underflow_o <= 1'b0;
    end else begin
      overflow_o  <= overflow_o  | (word_vld & full_o);
      underflow_o <= underflow_o | rd_under;
    end
  end
endmodule

// File: rtl/lc_checker.sv
module lc_checker #(
  parameter int unsigned SAMPLE_W = lc_pkg::LC_SAMPLE_W,
  parameter int unsigned DEPTH    = lc_pkg::LC_DEPTH,
  localparam int unsigned CW      = $clog2(DEPTH+1)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_line_start_i,
  input logic                rd_en_i,
  input logic [SAMPLE_W-1:0] rd_data_o,
  input logic                full_o,
  input logic                empty_o,
  input logic                overflow_o,
  input logic                underflow_o,
  input logic [CW-1:0]       word_cnt
);
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o)); // R3
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_cnt <= CW'(DEPTH)); // R3
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o); // R4
  AST_OVF_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> $past(full_o)); // R4
  AST_UNF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> underflow_o); // R5
  AST_UNF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underflow_o) |-> ($stable(rd_data_o) && $past(empty_o))); // R5
  AST_RD_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_en_i) |-> $stable(rd_data_o)); // R6
  AST_WSTART_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_line_start_i) |-> empty_o); // R7
endmodule

bind line_compander lc_checker #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH)) i_lc_checker (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .wr_line_start_i (wr_line_start_i),
  .rd_en_i         (rd_en_i),
  .rd_data_o       (rd_data_o),
  .full_o          (full_o),
  .empty_o         (empty_o),
  .overflow_o      (overflow_o),
  .underflow_o     (underflow_o),
  .word_cnt        (word_cnt)
);

// File: tb/test_line_compander.sv
module test_line_compander;
  localparam int SW = 7;
  localparam int NP = 4;
  localparam int ND = 188;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wls = 1'b0, we = 1'b0, rls = 1'b0, re = 1'b0;
  logic [SW-1:0] wd = '0;
  logic [SW-1:0] rd_data;
  logic          full, empty, ovf, unf;

  always #2.5 clk = ~clk;

  line_compander i_line_compander (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_line_start_i(wls), .wr_en_i(we), .wr_data_i(wd),
    .rd_line_start_i(rls), .rd_en_i(re), .rd_data_o(rd_data),
    .full_o(full), .empty_o(empty), .overflow_o(ovf), .underflow_o(unf)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  string cur_tag = "R2";

  // reference model state
  logic [SW*NP-1:0] mm [ND];
  logic [SW*NP-1:0] mword = '0;
  logic [SW-1:0]    mh [NP-1];
  int mwp = 0, mrp = 0, mwph = 0, mrph = 0, mcnt = 0;
  logic [SW-1:0] mout = '0;
  bit movf = 0, munf = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int winc = 0, rdec = 0;
    if (rls) begin mrp = 0; mrph = 0; end
    else if (re) begin
      if (mrph == 0) begin
        if (mcnt > 0) begin
          mword = mm[mrp]; mout = mword[SW-1:0];
          mrp = (mrp + 1) % ND; rdec = 1; mrph = 1;
        end else munf = 1;
      end else begin
        mout = mword[mrph*SW +: SW];
        mrph = (mrph + 1) % NP;
      end
    end
    if (wls) begin mwp = 0; mwph = 0; end
    else if (we) begin
      if (mwph == NP-1) begin
        if (mcnt == ND) movf = 1;
        else begin
          mm[mwp] = {wd, mh[2], mh[1], mh[0]};
          mwp = (mwp + 1) % ND; winc = 1;
        end
        mwph = 0;
      end else begin
        mh[mwph] = wd; mwph++;
      end
    end
    mcnt = wls ? 0 : mcnt + winc - rdec;
  endtask

  task automatic cyc(input bit we_, input logic [SW-1:0] wd_, input bit re_,
                     input bit wls_, input bit rls_);
    we = we_; wd = wd_; re = re_; wls = wls_; rls = rls_;
    @(posedge clk);
    model_step();
    #1;
    chk(cur_tag, rd_data, mout);
    chk("R3 full", full, mcnt == ND);
    chk("R3 empty", empty, mcnt == 0);
    chk("R4 overflow", ovf, movf);
    chk("R5 underflow", unf, munf);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, '0, 0, 0, 0);
  endtask

  task automatic random_run(input string tag, input int n, input int pw, input int pr);
    cur_tag = tag;
    for (int i = 0; i < n; i++)
      cyc(($urandom % 100) < pw, SW'($urandom), ($urandom % 100) < pr, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [SW-1:0] hold;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < NP-1; i++) mh[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 data", rd_data, 0); chk("R1 empty", empty, 1); chk("R1 full", full, 0);
    chk("R1 ovf", ovf, 0); chk("R1 unf", unf, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    chk("R1 data after release", rd_data, 0);

    // R2: ordered passage of two words
    cur_tag = "R2";
    for (int i = 0; i < 8; i++) cyc(1, SW'(i + 10), 0, 0, 0);
    chk("R2 two words stored", empty, 0);
    for (int i = 0; i < 8; i++) begin
      cyc(0, '0, 1, 0, 0);
      chk("R2 order", rd_data, i + 10);
    end
    // R6: output held without read strobe
    cur_tag = "R6";
    hold = rd_data;
    idle(3);
    chk("R6 hold", rd_data, hold);

    // R5: read while empty
    cur_tag = "R5";
    cyc(0, '0, 1, 0, 0);
    chk("R5 sticky set", unf, 1);
    chk("R5 data held", rd_data, hold);

    // R7: write line start discards partial word
    cur_tag = "R7";
    cyc(1, 7'd99, 0, 0, 0); cyc(1, 7'd98, 0, 0, 0);
    cyc(1, 7'd97, 0, 1, 1);
    chk("R7 empty after start", empty, 1);
    for (int i = 0; i < 4; i++) cyc(1, SW'(40 + i), 0, 0, 0);
    for (int i = 0; i < 4; i++) begin
      cyc(0, '0, 1, 0, 0);
      chk("R7 fresh word", rd_data, 40 + i);
    end

    // R8: read line start restarts at address 0
    cur_tag = "R8";
    cyc(0, '0, 0, 1, 1);
    for (int i = 0; i < 8; i++) cyc(1, SW'(60 + i), 0, 0, 0);
    cyc(0, '0, 1, 0, 0); cyc(0, '0, 1, 0, 0);
    cyc(0, '0, 0, 0, 1);
    cyc(0, '0, 1, 0, 0);
    chk("R8 reread word 0", rd_data, 60);

    // R4: overfill, dropped word invisible
    cur_tag = "R4";
    cyc(0, '0, 0, 1, 1);
    for (int i = 0; i < (ND + 1) * NP; i++) cyc(1, SW'(i * 3), 0, 0, 0);
    chk("R4 full", full, 1);
    chk("R4 overflow", ovf, 1);
    for (int i = 0; i < ND * NP; i++) cyc(0, '0, 1, 0, 0);
    chk("R4 drained", empty, 1);

    // R9: long streams through the wrap
    cyc(0, '0, 0, 1, 1);
    random_run("R9", 3000, 90, 85);
    // R10: unrelated rates, compress and expand
    random_run("R10", 3000, 70, 40);
    random_run("R10", 3000, 30, 80);
    random_run("R10", 3000, 55, 55);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule